// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Unit

This block keeps the privilege state of a small 32-bit core that runs in two modes, machine and user. It holds the current mode, a global interrupt enable and a one-deep record of the state before the last trap: the previous mode and the previous enable. It also holds the exception PC, the cause value and the trap-vector base. At each retiring instruction the pipeline presents that instruction's PC and what it is: an illegal instruction, an environment call, a trap return, or a control-register write. The block decides whether a trap or a return takes place, updates its state on the next clock edge, and in the same cycle gives the pipeline a redirect target.

A trap pushes the current mode and enable into the previous-state fields and enters machine mode with interrupts masked. A return pops them, loading the mode and enable from the saved fields and leaving the saved fields at user mode with interrupts enabled. Machine-mode software therefore enters user mode for the first time by writing a made-up saved state and then executing a return. An environment call is handled exactly like an illegal instruction, except for its cause code, which depends on the mode it came from. The exception PC keeps the address of the trapping instruction, and stepping past it is left to software.

Top module: `trap_return_unit`

## Requirements
- R1: After reset the mode is machine (encoding 2'b11), the interrupt enable is 0, the saved enable is 0, the saved mode is the reset parameter (default user, encoding 2'b00), and the exception PC, cause and vector base all read 0.
- R2: A taken trap sets the saved enable to the old enable, clears the enable, sets the saved mode to the old mode and the mode to machine. In the same cycle it raises the redirect to the vector base, whose bits [1:0] always read 0.
- R3: A return executed in machine mode loads the mode from the saved mode and the enable from the saved enable, then sets the saved mode to user and the saved enable to 1. In the same cycle it redirects to the exception PC. No other event lowers the mode.
- R4: An environment call traps with cause 8 from user mode and cause 11 from machine mode. The exception PC receives the call's own PC, with no increment.
- R5: An illegal instruction traps with cause 2 and stores its own PC as the exception PC.
- R6: A return executed in user mode is an illegal instruction (cause 2). It does not perform the return actions.
- R7: An interrupt is taken at a valid instruction when the interrupt input and the enable are both 1. It stores that instruction's PC, writes cause {1'b1, IRQ_CODE} (default 0x8000000B) and suppresses the instruction's own effects. Bit 31 of the cause is set by no other trap.
- R8: Priority among the events of one cycle, highest first: interrupt, exception, return, register write. When an illegal instruction and an environment call coincide, cause 2 is written.
- R9: The register selector picks 0 for status (bit 0 enable, bit 1 saved enable, bits [3:2] saved mode, other bits 0), 1 for the exception PC, 2 for cause and 3 for the vector base. Reads are combinational. Writes take effect at the next edge. The exception PC and the vector base store bits [1:0] as 0.
- R10: A status write whose saved-mode value is 2'b01 or 2'b10 leaves the saved mode unchanged while still writing the two enable bits.
- R11: A register write attempted in user mode traps as an illegal instruction (cause 2) and changes no register.
- R12: When the instruction-valid input is 0, all event inputs are ignored: there is no redirect and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | An instruction retires this cycle |
| instr_pc_i | input | XLEN | PC of the retiring instruction |
| illegal_i | input | 1 | Instruction is illegal |
| env_call_i | input | 1 | Instruction is an environment call |
| return_i | input | 1 | Instruction is a trap return |
| irq_i | input | 1 | Interrupt request level |
| csr_we_i | input | 1 | Instruction writes a trap register |
| csr_sel_i | input | 2 | Register selector for read and write |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the selected register |
| redirect_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | XLEN | Trap vector or return address |
| mode_o | output | 2 | Current mode (2'b11 machine, 2'b00 user) |
| irq_enable_o | output | 1 | Global interrupt enable |

## Verification
The hardest situations to reach are the ones in user mode with a chosen interrupt enable: the only way in is a return from a saved state that software has written beforehand. The bench therefore builds each case from scratch. It forces a trap to get back to machine mode, writes the saved mode and saved enable, and issues a return. It then presents one of all 32 combinations of interrupt, illegal, environment call, return and register write, in both modes and with both enable values. Expected mode, enable, status, exception PC, cause and vector base come from the priority rules alone.

// File: rtl/mtu_pkg.sv
package mtu_pkg;

   typedef enum logic [1:0] {
      MODE_U = 2'b00,
      MODE_M = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_EPC    = 2'd1,
      SEL_CAUSE  = 2'd2,
      SEL_VECTOR = 2'd3
   } csr_sel_e;

   localparam int CAUSE_ILLEGAL = 2;
   localparam int CAUSE_ENV_U   = 8;
   localparam int CAUSE_ENV_M   = 11;

   localparam int ST_IE    = 0;
   localparam int ST_PIE   = 1;
   localparam int ST_PMODE = 2;
   localparam int ST_W     = 4;

   function automatic logic mode_legal(input logic [1:0] m, input bit user_ok);
      return (m == MODE_M) || (user_ok && (m == MODE_U));
   endfunction

endpackage

// File: rtl/mtu_arbiter.sv
module mtu_arbiter
   import mtu_pkg::*;
#(
   parameter int CODE_W   = 5,
   parameter int IRQ_CODE = 11
) (
   input  logic              valid,
   input  logic              irq,
   input  logic              ill,
   input  logic              env,
   input  logic              ret,
   input  logic              csr_we,
   input  mode_e             cur_mode,
   input  logic              cur_ie,
   output logic              take_trap,
   output logic              trap_is_irq,
   output logic [CODE_W-1:0] trap_code,
   output logic              do_ret,
   output logic              do_csr_wr
);

   logic in_user;
   logic irq_hit;
   logic exc_hit;

   always_comb begin
      in_user     = (cur_mode == MODE_U);
      irq_hit     = valid && irq && cur_ie;
      exc_hit     = valid && (ill || env || (ret && in_user) || (csr_we && in_user));
      take_trap   = irq_hit || exc_hit;
      trap_is_irq = irq_hit;
      do_ret      = valid && ret && !irq_hit && !exc_hit;
      do_csr_wr   = valid && csr_we && !irq_hit && !exc_hit && !ret;
      if (irq_hit)
         trap_code = CODE_W'(IRQ_CODE);
      else if (env && !ill)
         trap_code = in_user ? CODE_W'(CAUSE_ENV_U) : CODE_W'(CAUSE_ENV_M);
      else
         trap_code = CODE_W'(CAUSE_ILLEGAL);
   end

endmodule

// File: rtl/mtu_status.sv
module mtu_status
   import mtu_pkg::*;
#(
   parameter bit    SUPPORT_USER    = 1'b1,
   parameter mode_e RESET_PREV_MODE = MODE_U
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_trap,
   input  logic       do_ret,
   input  logic       status_we,
   input  logic       w_ie,
   input  logic       w_pie,
   input  logic [1:0] w_pmode,
   output mode_e      mode,
   output logic       ie,
   output logic       pie,
   output mode_e      pmode
);

   localparam mode_e LEAST = SUPPORT_USER ? MODE_U : MODE_M;

   if (!mode_legal(RESET_PREV_MODE, SUPPORT_USER)) begin : g_bad_reset_mode
      $error("RESET_PREV_MODE is not a supported mode");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie  <= 1'b0;
         pie <= 1'b0;
      end else if (take_trap) begin
         pie <= ie;
         ie  <= 1'b0;
      end else if (do_ret) begin
         ie  <= pie;
         pie <= 1'b1;
      end else if (status_we) begin
         ie  <= w_ie;
         pie <= w_pie;
      end
   end

   if (SUPPORT_USER) begin : g_two_modes
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode  <= MODE_M;
            pmode <= RESET_PREV_MODE;
         end else if (take_trap) begin
            pmode <= mode;
            mode  <= MODE_M;
         end else if (do_ret) begin
            mode  <= pmode;
            pmode <= LEAST;
         end else if (status_we && mode_legal(w_pmode, SUPPORT_USER)) begin
            pmode <= mode_e'(w_pmode);
         end
      end
   end else begin : g_machine_only
      assign mode  = MODE_M;
      assign pmode = MODE_M;
   end

   a_r2_trap_enters_machine: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> (mode == MODE_M) && !ie);

   a_r2_trap_pushes_state: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> (pie == $past(ie)) && (pmode == $past(mode)));

   a_r3_return_pops_state: assert property (@(posedge clk) disable iff (!rst_n)
      do_ret |=> (mode == $past(pmode)) && (ie == $past(pie)) && (pmode == LEAST) && pie);

   a_r3_lower_only_by_return: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_M) && !do_ret |=> (mode == MODE_M));

   a_r10_saved_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_legal(pmode, SUPPORT_USER));

endmodule

// File: rtl/mtu_regs.sv
module mtu_regs
   import mtu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_trap,
   input  logic              trap_is_irq,
   input  logic [CODE_W-1:0] trap_code,
   input  logic [XLEN-1:0]   pc,
   input  logic              wr_en,
   input  logic [1:0]        sel,
   input  logic [XLEN-1:0]   wdata,
   input  logic [ST_W-1:0]   status_bits,
   output logic [XLEN-1:0]   epc,
   output logic [XLEN-1:0]   vector,
   output logic [XLEN-1:0]   rdata
);

   localparam logic [XLEN-1:0] ALIGN = ~XLEN'(3);
   localparam int              PAD_W = XLEN - 1 - CODE_W;

   logic [XLEN-1:0] cause;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc    <= '0;
         cause  <= '0;
         vector <= '0;
      end else if (take_trap) begin
         epc   <= pc & ALIGN;
         cause <= {trap_is_irq, {PAD_W{1'b0}}, trap_code};
      end else if (wr_en) begin
         case (csr_sel_e'(sel))
            SEL_EPC:    epc    <= wdata & ALIGN;
            SEL_CAUSE:  cause  <= wdata;
            SEL_VECTOR: vector <= wdata & ALIGN;
            default:    ;
         endcase
      end
   end

   always_comb begin
      case (csr_sel_e'(sel))
         SEL_STATUS: rdata = XLEN'(status_bits);
         SEL_EPC:    rdata = epc;
         SEL_CAUSE:  rdata = cause;
         default:    rdata = vector;
      endcase
   end

   a_r7_cause_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> (cause[XLEN-1] == $past(trap_is_irq)));

   a_r4_epc_is_own_pc: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> (epc == $past(pc & ALIGN)));

   a_r9_aligned_pointers: assert property (@(posedge clk) disable iff (!rst_n)
      (epc[1:0] == 2'b00) && (vector[1:0] == 2'b00));

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
   import mtu_pkg::*;
#(
   parameter int    XLEN            = 32,
   parameter int    CODE_W          = 5,
   parameter int    IRQ_CODE        = 11,
   parameter bit    SUPPORT_USER    = 1'b1,
   parameter mode_e RESET_PREV_MODE = MODE_U
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid_i,
   input  logic [XLEN-1:0] instr_pc_i,
   input  logic            illegal_i,
   input  logic            env_call_i,
   input  logic            return_i,
   input  logic            irq_i,
   input  logic            csr_we_i,
   input  logic [1:0]      csr_sel_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   output logic [XLEN-1:0] csr_rdata_o,
   output logic            redirect_o,
   output logic [XLEN-1:0] redirect_pc_o,
   output logic [1:0]      mode_o,
   output logic            irq_enable_o
);

   if (XLEN < 16) begin : g_bad_xlen
      $error("XLEN must be at least 16");
   end
   if (CODE_W + 1 >= XLEN) begin : g_bad_code_w
      $error("CODE_W leaves no room for the interrupt flag");
   end
   if (IRQ_CODE >= (1 << CODE_W) || CAUSE_ENV_M >= (1 << CODE_W)) begin : g_bad_code
      $error("cause codes do not fit CODE_W");
   end

   logic              take_trap;
   logic              trap_is_irq;
   logic [CODE_W-1:0] trap_code;
   logic              do_ret;
   logic              do_csr_wr;
   mode_e             mode;
   mode_e             pmode;
   logic              ie;
   logic              pie;
   logic [XLEN-1:0]   epc;
   logic [XLEN-1:0]   vector;
   logic [ST_W-1:0]   status_bits;
   logic              status_we;

   mtu_arbiter #(
      .CODE_W   (CODE_W),
      .IRQ_CODE (IRQ_CODE)
   ) i_arbiter (
      .valid       (instr_valid_i),
      .irq         (irq_i),
      .ill         (illegal_i),
      .env         (env_call_i),
      .ret         (return_i),
      .csr_we      (csr_we_i),
      .cur_mode    (mode),
      .cur_ie      (ie),
      .take_trap   (take_trap),
      .trap_is_irq (trap_is_irq),
      .trap_code   (trap_code),
      .do_ret      (do_ret),
      .do_csr_wr   (do_csr_wr)
   );

   assign status_we = do_csr_wr && (csr_sel_e'(csr_sel_i) == SEL_STATUS);

   mtu_status #(
      .SUPPORT_USER    (SUPPORT_USER),
      .RESET_PREV_MODE (RESET_PREV_MODE)
   ) i_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_trap (take_trap),
      .do_ret    (do_ret),
      .status_we (status_we),
      .w_ie      (csr_wdata_i[ST_IE]),
      .w_pie     (csr_wdata_i[ST_PIE]),
      .w_pmode   (csr_wdata_i[ST_PMODE+1:ST_PMODE]),
      .mode      (mode),
      .ie        (ie),
      .pie       (pie),
      .pmode     (pmode)
   );

   assign status_bits = {pmode, pie, ie};

   mtu_regs #(
      .XLEN   (XLEN),
      .CODE_W (CODE_W)
   ) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_trap   (take_trap),
      .trap_is_irq (trap_is_irq),
      .trap_code   (trap_code),
      .pc          (instr_pc_i),
      .wr_en       (do_csr_wr),
      .sel         (csr_sel_i),
      .wdata       (csr_wdata_i),
      .status_bits (status_bits),
      .epc         (epc),
      .vector      (vector),
      .rdata       (csr_rdata_o)
   );

   assign redirect_o    = take_trap || do_ret;
   assign redirect_pc_o = take_trap ? vector : epc;
   assign mode_o        = mode;
   assign irq_enable_o  = ie;

   a_r8_single_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({take_trap, do_ret, do_csr_wr}));

   a_r12_idle_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid_i |-> !redirect_o);

   a_r12_idle_holds_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid_i |=> (mode_o == $past(mode_o)) && (irq_enable_o == $past(irq_enable_o)));

   a_r2_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> (redirect_pc_o[1:0] == 2'b00));

   a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i && !irq_enable_o && !illegal_i && !env_call_i && !return_i && !csr_we_i)
         |-> !redirect_o);

endmodule

// File: tb/test_trap_return_unit.sv
module test_trap_return_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid_i = 1'b0;
   logic [31:0] instr_pc_i = '0;
   logic        illegal_i = 1'b0;
   logic        env_call_i = 1'b0;
   logic        return_i = 1'b0;
   logic        irq_i = 1'b0;
   logic        csr_we_i = 1'b0;
   logic [1:0]  csr_sel_i = '0;
   logic [31:0] csr_wdata_i = '0;
   logic [31:0] csr_rdata_o;
   logic        redirect_o;
   logic [31:0] redirect_pc_o;
   logic [1:0]  mode_o;
   logic        irq_enable_o;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   trap_return_unit i_trap_return_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_pc_i(instr_pc_i),
      .illegal_i(illegal_i), .env_call_i(env_call_i), .return_i(return_i), .irq_i(irq_i),
      .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
      .csr_rdata_o(csr_rdata_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
      .mode_o(mode_o), .irq_enable_o(irq_enable_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_inputs();
      instr_valid_i = 1'b0; illegal_i = 1'b0; env_call_i = 1'b0; return_i = 1'b0;
      irq_i = 1'b0; csr_we_i = 1'b0; csr_wdata_i = '0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      instr_valid_i = 1'b1; csr_we_i = 1'b1; csr_sel_i = sel; csr_wdata_i = data;
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] data);
      csr_sel_i = sel;
      #1;
      data = csr_rdata_o;
   endtask

   task automatic force_trap();
      @(negedge clk);
      instr_valid_i = 1'b1; illegal_i = 1'b1;
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic do_return();
      @(negedge clk);
      instr_valid_i = 1'b1; return_i = 1'b1;
      @(negedge clk);
      clear_inputs();
   endtask

   initial begin
      logic [31:0] v;
      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 mode", 32'(mode_o), 32'd3);
      chk("R1 enable", 32'(irq_enable_o), 32'd0);
      rd(2'd0, v); chk("R1 status", v, 32'h0);
      rd(2'd1, v); chk("R1 epc", v, 32'h0);
      rd(2'd2, v); chk("R1 cause", v, 32'h0);
      rd(2'd3, v); chk("R1 vector", v, 32'h0);

      // R9 alignment of stored pointers
      wr(2'd1, 32'h0000_1237); rd(2'd1, v); chk("R9 epc aligned", v, 32'h0000_1234);
      wr(2'd3, 32'h0000_4003); rd(2'd3, v); chk("R9 vector aligned", v, 32'h0000_4000);
      wr(2'd2, 32'hA5A5_0001); rd(2'd2, v); chk("R9 cause write", v, 32'hA5A5_0001);

      // R10 unsupported saved-mode writes
      wr(2'd0, 32'h0); rd(2'd0, v); chk("R10 base status", v, 32'h0);
      wr(2'd0, 32'hB);  rd(2'd0, v); chk("R10 mode 2 ignored", v, 32'h3);
      wr(2'd0, 32'h4);  rd(2'd0, v); chk("R10 mode 1 ignored", v, 32'h0);
      wr(2'd0, 32'hC);  rd(2'd0, v); chk("R10 machine accepted", v, 32'hC);

      // R3 return to machine mode when the saved mode is machine
      do_return();
      #1;
      chk("R3 stays machine", 32'(mode_o), 32'd3);
      chk("R3 enable from saved", 32'(irq_enable_o), 32'd0);
      rd(2'd0, v); chk("R3 saved reset to user", v, 32'h2);

      // R12 events without instr_valid are ignored
      wr(2'd0, 32'h1);
      @(negedge clk);
      illegal_i = 1'b1; env_call_i = 1'b1; return_i = 1'b1; irq_i = 1'b1;
      csr_we_i = 1'b1; csr_sel_i = 2'd0; csr_wdata_i = 32'hC;
      #1;
      chk("R12 no redirect", 32'(redirect_o), 32'd0);
      @(negedge clk);
      clear_inputs();
      #1;
      chk("R12 mode kept", 32'(mode_o), 32'd3);
      rd(2'd0, v); chk("R12 status kept", v, 32'h1);
      rd(2'd2, v); chk("R12 cause kept", v, 32'hA5A5_0001);

      // Sweep: R2 R3 R4 R5 R6 R7 R8 R11 over both modes, both enables, all event mixes
      for (int mu = 0; mu < 2; mu++) begin
         for (int en = 0; en < 2; en++) begin
            for (int c = 0; c < 32; c++) begin
               int idx;
               logic [31:0] tv, ep, pc, cdat;
               bit ev_irq, ev_ill, ev_env, ev_ret, ev_csr, user;
               bit e_irq, e_exc;
               logic [31:0] e_cause, e_epc, e_vec, e_status, e_target;
               logic [1:0] e_mode;
               logic e_ie, e_redir;
               idx  = mu * 64 + en * 32 + c;
               tv   = 32'h0000_4000 + 32'(idx) * 16;
               ep   = 32'h0001_0000 + 32'(idx) * 8;
               pc   = 32'h0002_0000 + 32'(idx) * 4;
               cdat = 32'h0003_0001 + 32'(idx) * 16;
               ev_irq = c[0]; ev_ill = c[1]; ev_env = c[2]; ev_ret = c[3]; ev_csr = c[4];
               user = (mu == 1);

               force_trap();
               wr(2'd3, tv | 32'h3);
               wr(2'd2, 32'h55);
               wr(2'd1, ep);
               wr(2'd0, {28'h0, (user ? 2'b00 : 2'b11), en[0], 1'b0});
               do_return();

               // expected outcome from the priority rules
               e_irq = ev_irq && (en == 1);
               e_exc = !e_irq && (ev_ill || ev_env || (ev_ret && user) || (ev_csr && user));
               e_redir = 1'b0; e_target = 32'h0;
               e_mode = user ? 2'b00 : 2'b11; e_ie = en[0];
               e_status = {28'h0, 2'b00, 1'b1, en[0]};
               e_cause = 32'h55; e_epc = ep; e_vec = tv;
               if (e_irq || e_exc) begin
                  e_redir = 1'b1; e_target = tv;
                  e_mode = 2'b11; e_ie = 1'b0;
                  e_status = {28'h0, (user ? 2'b00 : 2'b11), en[0], 1'b0};
                  e_epc = pc;
                  if (e_irq) e_cause = 32'h8000_000B;
                  else if (ev_ill) e_cause = 32'd2;
                  else if (ev_env) e_cause = user ? 32'd8 : 32'd11;
                  else e_cause = 32'd2;
               end else if (ev_ret) begin
                  e_redir = 1'b1; e_target = ep;
                  e_mode = 2'b00; e_ie = 1'b1;
                  e_status = 32'h2 | 32'h1;
               end else if (ev_csr) begin
                  e_vec = cdat & ~32'h3;
               end

               @(negedge clk);
               instr_valid_i = 1'b1; instr_pc_i = pc;
               irq_i = ev_irq; illegal_i = ev_ill; env_call_i = ev_env;
               return_i = ev_ret; csr_we_i = ev_csr; csr_sel_i = 2'd3; csr_wdata_i = cdat;
               #1;
               chk($sformatf("R8 redirect case %0d", idx), 32'(redirect_o), 32'(e_redir));
               if (e_redir)
                  chk($sformatf("R2 target case %0d", idx), redirect_pc_o, e_target);
               @(negedge clk);
               clear_inputs();
               #1;
               chk($sformatf("R2 mode case %0d", idx), 32'(mode_o), 32'(e_mode));
               chk($sformatf("R3 enable case %0d", idx), 32'(irq_enable_o), 32'(e_ie));
               rd(2'd0, v); chk($sformatf("R2 status case %0d", idx), v, e_status);
               rd(2'd2, v); chk($sformatf("R4 R5 R6 R7 cause case %0d", idx), v, e_cause);
               rd(2'd1, v); chk($sformatf("R4 epc case %0d", idx), v, e_epc);
               rd(2'd3, v); chk($sformatf("R11 vector case %0d", idx), v, e_vec);
            end
         end
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule